// File: doc/BRIEF.md
# Processor Slot Hotplug Register Controller

This block is the guest-visible register window for adding and removing processors at run time. It tracks a parameterised number of processor slots. The host marks a slot as added, or asks for its removal, with one-cycle pulses on per-slot inputs. Guest firmware reaches the block through a 32-bit, byte-enabled write bus with a 2-bit word index, which covers a 12-byte window of three words. Reads are combinational from the word index.

The block leaves reset in a compatibility view. In that view, reads return a bitmap of the slots that are present, and firmware can do nothing except leave the view. After the switch, firmware works through an indexed view:

- a slot selector;
- a status/control byte for the selected slot;
- a command byte;
- a data word.

Command 0 finds the lowest-numbered slot with a pending event. Commands 1 and 2 load two reporting registers, and the second of these raises a notify strobe toward the host. A guest eject request produces a one-cycle eject pulse that carries the slot index. An interrupt line stays high while any event is pending.

Top module: `slot_hp_ctrl`

## Requirements
- R1: After reset the block is in the bitmap view, every slot is absent, `irq_o`, `eject_o` and `notify_o` are low, and every word reads as zero.
- R2: In the bitmap view, bit j of word w reads 1 exactly when slot 32·w+j is enabled. Word index 3 reads zero.
- R3: In the bitmap view, the only write with an effect is a write of 0x00000000 with all four byte enables to word 0. That write moves the block for good into the indexed view. Every other write, including a nonzero write to word 0, changes nothing.
- R4: In the indexed view, a write to word 0 loads the slot selector byte by byte under the byte enables. Word 0 and word 3 read as zero. The selector changes only through a bus write.
- R5: In the indexed view, word 1 reads {29'b0, remove-pending, insert-pending, enabled} for the selected slot. It reads zero when the selector is not below the slot count.
- R6: A write to word 1 with byte enable 0 set acts on the selected slot. Bit 1 clears the slot's insert event and bit 2 clears its remove event. Bit 0 and bits 7:4 have no effect. With the selector out of range, the write has no effect.
- R7: Bit 3 of the byte in R6 requests an eject. In the next cycle `eject_o` is high for one cycle and `eject_slot_o` holds the selector. From then on the slot reads not enabled and its remove event is clear.
- R8: A hot-add pulse sets the slot's enabled and insert bits. A remove pulse sets the remove bit, but only for an enabled slot. Host pulses take precedence over guest clears and ejects in the same cycle.
- R9: `irq_o` is high exactly when some slot has an insert or remove event pending.
- R10: A write to word 1 with byte enable 1 stores bits 15:8 as the command. A command of 0 loads the selector, at that clock edge, with the lowest-numbered slot that has an event. If no slot has an event, the selector is left unchanged.
- R11: With command 1, a write to word 2 loads the event register (`ost_event_o`). With command 2, it loads the status register (`ost_status_o`). In both cases bytes are merged under the enables. A command-2 write raises `notify_o` for one cycle, in the next cycle, while both registers show their new values.
- R12: A read of word 2 returns the selector when the command is 0, and 0xFFFFFFFF for any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_add_i | input | N_SLOTS | Per-slot hot-add pulse |
| hp_rmreq_i | input | N_SLOTS | Per-slot removal-request pulse |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 2 | Word index within the window |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Event-pending interrupt |
| eject_o | output | 1 | One-cycle eject pulse |
| eject_slot_o | output | IDX_W | Slot index that goes with `eject_o` |
| notify_o | output | 1 | One-cycle notify pulse after a status write |
| ost_event_o | output | 32 | Event reporting register |
| ost_status_o | output | 32 | Status reporting register |

## Verification
Host pulses and guest writes to the same slot can land on the same clock edge. A hot-add can coincide with a clear of that slot's insert event. A removal pulse can coincide with an eject or a remove-event clear. The bench drives these pairs together in one cycle, both in directed steps and in a random phase that overlaps bus writes with sparse host pulses. Its model applies the guest action first and the host action last, so the host wins. The bench then reads the status byte and `irq_o` to see which side held.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned MAP_WORDS = 3;
    localparam int unsigned MAP_BITS = MAP_WORDS * BUS_W;

    typedef enum logic [1:0] {
        WIN_SEL  = 2'd0,
        WIN_CTL  = 2'd1,
        WIN_DATA = 2'd2,
        WIN_GAP  = 2'd3
    } win_e;

    localparam logic [7:0] CMD_SCAN   = 8'd0;
    localparam logic [7:0] CMD_OST_EV = 8'd1;
    localparam logic [7:0] CMD_OST_ST = 8'd2;

    localparam int unsigned CTL_CLR_INS = 1;
    localparam int unsigned CTL_CLR_RM  = 2;
    localparam int unsigned CTL_EJECT   = 3;

    typedef struct packed {
        logic rm;
        logic ins;
        logic on;
    } slot_st_t;

    typedef struct packed {
        logic clr_ins;
        logic clr_rm;
        logic eject;
    } slot_req_t;

    function automatic logic [7:0] status_byte(input slot_st_t s);
        return {5'b0, s.rm, s.ins, s.on};
    endfunction

    function automatic logic [BUS_W-1:0] merge_be(input logic [BUS_W-1:0] old_v,
                                                 input logic [BUS_W-1:0] new_v,
                                                 input logic [3:0] be);
        logic [BUS_W-1:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/slot_hp_cell.sv
module slot_hp_cell
    import slot_hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      add_i,
    input  logic      rmreq_i,
    input  slot_req_t req_i,
    output slot_st_t  st_o
);
    slot_st_t st_q;

    // Guest actions first, host actions last: host wins on a shared edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (req_i.eject) begin
                st_q.on <= 1'b0;
                st_q.rm <= 1'b0;
            end
            if (req_i.clr_ins) st_q.ins <= 1'b0;
            if (req_i.clr_rm)  st_q.rm  <= 1'b0;
            if (rmreq_i && st_q.on) st_q.rm <= 1'b1;
            if (add_i) begin
                st_q.on  <= 1'b1;
                st_q.ins <= 1'b1;
            end
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/slot_hp_scan.sv
module slot_hp_scan #(
    parameter int unsigned N_SLOTS = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [N_SLOTS-1:0] pend_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Walk downward so the lowest pending index is the last one written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
    import slot_hp_pkg::*;
#(
    parameter int unsigned N_SLOTS = 8,
    localparam int unsigned IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SLOTS-1:0] hp_add_i,
    input  logic [N_SLOTS-1:0] hp_rmreq_i,
    input  logic               bus_wr_i,
    input  logic [1:0]         bus_addr_i,
    input  logic [3:0]         bus_be_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o,
    output logic               eject_o,
    output logic [IDX_W-1:0]   eject_slot_o,
    output logic               notify_o,
    output logic [31:0]        ost_event_o,
    output logic [31:0]        ost_status_o
);
    localparam int unsigned SLOT_SPAN = 1 << IDX_W;

    logic             reg_mode_q;
    logic [31:0]      sel_q;
    logic [7:0]       cmd_q;
    logic [31:0]      ev_q;
    logic [31:0]      stat_q;
    logic             notify_q;
    logic             eject_q;
    logic [IDX_W-1:0] eject_idx_q;

    slot_st_t         st_arr [SLOT_SPAN];
    logic [N_SLOTS-1:0] on_v;
    logic [N_SLOTS-1:0] pend_v;
    logic [MAP_BITS-1:0] map_v;

    win_e             win;
    logic             sel_ok;
    logic [IDX_W-1:0] sel_idx;
    logic             wr_reg;
    logic             ctl_wr;
    logic             cmd_wr;
    logic             data_wr;
    logic             leave_map;
    logic [7:0]       ctl_byte;
    logic [7:0]       cmd_byte;
    logic             scan_found;
    logic [IDX_W-1:0] scan_idx;

    assign win      = win_e'(bus_addr_i);
    assign sel_ok   = sel_q < 32'(N_SLOTS);
    assign sel_idx  = sel_q[IDX_W-1:0];
    assign ctl_byte = bus_wdata_i[7:0];
    assign cmd_byte = bus_wdata_i[15:8];

    assign wr_reg    = bus_wr_i && reg_mode_q;
    assign ctl_wr    = wr_reg && (win == WIN_CTL) && bus_be_i[0] && sel_ok;
    assign cmd_wr    = wr_reg && (win == WIN_CTL) && bus_be_i[1];
    assign data_wr   = wr_reg && (win == WIN_DATA);
    assign leave_map = bus_wr_i && !reg_mode_q && (win == WIN_SEL)
                       && (bus_be_i == 4'hF) && (bus_wdata_i == 32'h0);

    // Per-slot state, padded to a power of two so the selector can index it.
    for (genvar i = 0; i < SLOT_SPAN; i++) begin : g_slot
        if (i < N_SLOTS) begin : g_live
            slot_req_t req;
            logic      hit;
            assign hit         = ctl_wr && (sel_idx == IDX_W'(i));
            assign req.clr_ins = hit && ctl_byte[CTL_CLR_INS];
            assign req.clr_rm  = hit && ctl_byte[CTL_CLR_RM];
            assign req.eject   = hit && ctl_byte[CTL_EJECT];

            slot_hp_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .add_i   (hp_add_i[i]),
                .rmreq_i (hp_rmreq_i[i]),
                .req_i   (req),
                .st_o    (st_arr[i])
            );
            assign on_v[i]   = st_arr[i].on;
            assign pend_v[i] = st_arr[i].ins || st_arr[i].rm;
        end else begin : g_pad
            assign st_arr[i] = '0;
        end
    end

    for (genvar k = 0; k < MAP_BITS; k++) begin : g_map
        if (k < N_SLOTS) begin : g_bit
            assign map_v[k] = on_v[k];
        end else begin : g_zero
            assign map_v[k] = 1'b0;
        end
    end

    slot_hp_scan #(
        .N_SLOTS (N_SLOTS),
        .IDX_W   (IDX_W)
    ) u_scan (
        .pend_i  (pend_v),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_mode_q  <= 1'b0;
            sel_q       <= '0;
            cmd_q       <= CMD_SCAN;
            ev_q        <= '0;
            stat_q      <= '0;
            notify_q    <= 1'b0;
            eject_q     <= 1'b0;
            eject_idx_q <= '0;
        end else begin
            notify_q <= 1'b0;
            eject_q  <= 1'b0;
            if (leave_map) reg_mode_q <= 1'b1;
            if (wr_reg && (win == WIN_SEL)) begin
                sel_q <= merge_be(sel_q, bus_wdata_i, bus_be_i);
            end
            if (cmd_wr) begin
                cmd_q <= cmd_byte;
                if ((cmd_byte == CMD_SCAN) && scan_found) begin
                    sel_q <= 32'(scan_idx);
                end
            end
            if (ctl_wr && ctl_byte[CTL_EJECT]) begin
                eject_q     <= 1'b1;
                eject_idx_q <= sel_idx;
            end
            if (data_wr && (cmd_q == CMD_OST_EV)) begin
                ev_q <= merge_be(ev_q, bus_wdata_i, bus_be_i);
            end
            if (data_wr && (cmd_q == CMD_OST_ST)) begin
                stat_q   <= merge_be(stat_q, bus_wdata_i, bus_be_i);
                notify_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (!reg_mode_q) begin
            if (win != WIN_GAP) begin
                bus_rdata_o = map_v[BUS_W*int'(bus_addr_i) +: BUS_W];
            end
        end else begin
            unique case (win)
                WIN_CTL:  if (sel_ok) bus_rdata_o = {24'b0, status_byte(st_arr[sel_idx])};
                WIN_DATA: bus_rdata_o = (cmd_q == CMD_SCAN) ? sel_q : 32'hFFFF_FFFF;
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o        = |pend_v;
    assign eject_o      = eject_q;
    assign eject_slot_o = eject_idx_q;
    assign notify_o     = notify_q;
    assign ost_event_o  = ev_q;
    assign ost_status_o = stat_q;
endmodule

// File: rtl/slot_hp_chk.sv
module slot_hp_chk #(
    parameter int unsigned N_SLOTS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [N_SLOTS-1:0] hp_add_i,
    input logic [N_SLOTS-1:0] hp_rmreq_i,
    input logic               bus_wr_i,
    input logic [1:0]         bus_addr_i,
    input logic [3:0]         bus_be_i,
    input logic [31:0]        bus_wdata_i,
    input logic               irq_o,
    input logic               eject_o,
    input logic               notify_o,
    input logic [31:0]        ost_event_o,
    input logic [31:0]        ost_status_o,
    input logic [31:0]        sel_q
);
    // R7
    eject_cause_chk: assert property (@(posedge clk) disable iff (rst)
        eject_o |-> $past(bus_wr_i && bus_addr_i == 2'd1 && bus_be_i[0] && bus_wdata_i[3]));

    // R11
    notify_cause_chk: assert property (@(posedge clk) disable iff (rst)
        notify_o |-> $past(bus_wr_i && bus_addr_i == 2'd2));

    // R11
    notify_value_chk: assert property (@(posedge clk) disable iff (rst)
        (notify_o && $past(bus_be_i) == 4'hF) |-> ost_status_o == $past(bus_wdata_i));

    // R11
    event_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ost_event_o) |-> $past(bus_wr_i && bus_addr_i == 2'd2));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past((|hp_add_i) || (|hp_rmreq_i)));

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(bus_wr_i));

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!bus_wr_i) |-> $stable(sel_q));
endmodule

bind slot_hp_ctrl slot_hp_chk #(.N_SLOTS(N_SLOTS)) u_chk (.*);

// File: tb/sim_slot_hp_ctrl.sv
module sim_slot_hp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] hp_add = '0;
    logic [NS-1:0] hp_rmq = '0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rdata;
    logic          irq, eject, notify;
    logic [2:0]    eject_slot;
    logic [31:0]   ost_ev, ost_st;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the requirements
    logic          m_mode = 1'b0;
    logic [31:0]   m_sel = '0;
    logic [7:0]    m_cmd = '0;
    logic [31:0]   m_ev = '0;
    logic [31:0]   m_st = '0;
    logic [NS-1:0] m_on = '0;
    logic [NS-1:0] m_ins = '0;
    logic [NS-1:0] m_rm = '0;

    slot_hp_ctrl #(.N_SLOTS(NS)) u0 (
        .clk(clk), .rst(rst), .hp_add_i(hp_add), .hp_rmreq_i(hp_rmq),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_be_i(bus_be),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata), .irq_o(irq),
        .eject_o(eject), .eject_slot_o(eject_slot), .notify_o(notify),
        .ost_event_o(ost_ev), .ost_status_o(ost_st)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        logic [95:0] map;
        int unsigned s;
        map = '0;
        map[NS-1:0] = m_on;
        if (!m_mode) return (a == 2'd3) ? 32'h0 : map[32*int'(a) +: 32];
        case (a)
            2'd1: begin
                if (m_sel >= NS) return 32'h0;
                s = m_sel;
                return {29'b0, m_rm[s], m_ins[s], m_on[s]};
            end
            2'd2: return (m_cmd == 8'd0) ? m_sel : 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    // One clock cycle with optional write and host pulses; checks the pulse outputs.
    task automatic cyc(input logic w, input logic [1:0] a, input logic [3:0] be,
                       input logic [31:0] d, input logic [NS-1:0] ad, input logic [NS-1:0] rq);
        logic [NS-1:0] pend, old_on;
        logic ej, nt, found;
        int unsigned ejx, s, fidx;
        bus_wr = w; bus_addr = a; bus_be = be; bus_wdata = d; hp_add = ad; hp_rmq = rq;
        @(posedge clk);
        pend = m_ins | m_rm; old_on = m_on; ej = 0; nt = 0; ejx = 0;
        found = 0; fidx = 0;
        for (int i = NS - 1; i >= 0; i--) if (pend[i]) begin found = 1; fidx = i; end
        if (w && m_mode) begin
            case (a)
                2'd0: m_sel = mrg(m_sel, d, be);
                2'd1: begin
                    if (be[0] && m_sel < NS) begin
                        s = m_sel;
                        if (d[1]) m_ins[s] = 0;
                        if (d[2]) m_rm[s] = 0;
                        if (d[3]) begin m_on[s] = 0; m_rm[s] = 0; ej = 1; ejx = s; end
                    end
                    if (be[1]) begin
                        m_cmd = d[15:8];
                        if (d[15:8] == 8'd0 && found) m_sel = fidx;
                    end
                end
                2'd2: begin
                    if (m_cmd == 8'd1) m_ev = mrg(m_ev, d, be);
                    else if (m_cmd == 8'd2) begin m_st = mrg(m_st, d, be); nt = 1; end
                end
                default: ;
            endcase
        end else if (w && a == 2'd0 && be == 4'hF && d == 32'h0) begin
            m_mode = 1;
        end
        for (int i = 0; i < NS; i++) begin
            if (rq[i] && old_on[i]) m_rm[i] = 1;
            if (ad[i]) begin m_on[i] = 1; m_ins[i] = 1; end
        end
        @(negedge clk);
        bus_wr = 0; hp_add = '0; hp_rmq = '0;
        chk("R7 eject pulse", {31'b0, eject}, {31'b0, ej});
        if (ej) chk("R7 eject slot", {29'b0, eject_slot}, ejx);
        chk("R11 notify pulse", {31'b0, notify}, {31'b0, nt});
        chk("R11 event reg", ost_ev, m_ev);
        chk("R11 status reg", ost_st, m_st);
        chk("R9 irq", {31'b0, irq}, {31'b0, |(m_ins | m_rm)});
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        cyc(1'b1, a, be, d, '0, '0);
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        bus_addr = a;
        #1;
        chk(tag, rdata, exp_read(a));
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd("R1 word0", 2'd0);
        rd("R1 word1", 2'd1);
        rd("R1 word2", 2'd2);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 eject/notify", {30'b0, eject, notify}, 32'h0);

        // R2/R8 bitmap view after hot-adds
        cyc(1'b0, 2'd0, 4'h0, 32'h0, 8'h28, 8'h00);
        bus_addr = 2'd0; #1; chk("R2 bitmap literal", rdata, 32'h28); @(negedge clk);
        rd("R2 word1 zero", 2'd1);
        rd("R2 word3 zero", 2'd3);

        // R3 ignored writes in bitmap view
        wr(2'd0, 4'hF, 32'h1);
        wr(2'd1, 4'h3, 32'h0006);
        wr(2'd0, 4'h7, 32'h0);
        bus_addr = 2'd0; #1; chk("R3 still bitmap", rdata, 32'h28); @(negedge clk);
        chk("R3 irq kept", {31'b0, irq}, 32'h1);

        // R3/R4 switch to indexed view
        wr(2'd0, 4'hF, 32'h0);
        rd("R4 word0 zero", 2'd0);

        // R10 scan finds slot 3
        wr(2'd1, 4'h2, 32'h0);
        bus_addr = 2'd2; #1; chk("R10 scan literal", rdata, 32'd3); @(negedge clk);
        bus_addr = 2'd1; #1; chk("R5 status literal", rdata, 32'h3); @(negedge clk);

        // R6 clear insert with ignored bits set
        wr(2'd1, 4'h1, 32'h00F3);
        rd("R6 insert cleared", 2'd1);
        wr(2'd1, 4'h2, 32'h0);
        rd("R10 next slot", 2'd2);
        wr(2'd1, 4'h1, 32'h0002);
        wr(2'd0, 4'hF, 32'd6);
        wr(2'd1, 4'h2, 32'h0);
        rd("R10 none pending keeps sel", 2'd2);

        // R8 remove request on absent and present slots
        cyc(1'b0, 2'd0, 4'h0, 32'h0, 8'h00, 8'h80);
        wr(2'd0, 4'hF, 32'd7);
        rd("R8 absent slot no remove", 2'd1);
        cyc(1'b0, 2'd0, 4'h0, 32'h0, 8'h00, 8'h08);
        wr(2'd0, 4'hF, 32'd3);
        rd("R8 remove pending", 2'd1);

        // R7 eject slot 3
        wr(2'd1, 4'h1, 32'h0008);
        rd("R7 after eject", 2'd1);

        // R8 hot-add and clear on the same edge: host wins
        wr(2'd0, 4'hF, 32'd4);
        cyc(1'b1, 2'd1, 4'h1, 32'h0002, 8'h10, 8'h00);
        rd("R8 add beats clear", 2'd1);

        // R5/R6 selector out of range
        wr(2'd0, 4'hF, 32'd100);
        rd("R5 out of range status", 2'd1);
        wr(2'd1, 4'h1, 32'h000E);
        rd("R12 data shows sel", 2'd2);
        wr(2'd0, 4'hF, 32'd4);
        rd("R6 out of range no effect", 2'd1);

        // R11/R12 reporting registers
        wr(2'd1, 4'h2, 32'h0100);
        rd("R12 cmd1 read", 2'd2);
        wr(2'd2, 4'hF, 32'hA5A5_0001);
        wr(2'd1, 4'h2, 32'h0200);
        wr(2'd2, 4'hF, 32'h0000_BEEF);
        wr(2'd2, 4'h4, 32'h0077_0000);
        wr(2'd1, 4'h2, 32'h0700);
        rd("R12 unsupported cmd", 2'd2);

        // Random phase
        for (int k = 0; k < 600; k++) begin
            logic [1:0] a;
            logic [3:0] be;
            logic [31:0] d;
            logic [NS-1:0] ad, rq;
            a = 2'($urandom % 3);
            be = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
            d = $urandom;
            if (a == 2'd0) d = $urandom % (NS + 3);
            if (a == 2'd1) begin
                d = {16'h0, 8'($urandom % 4), 8'($urandom)};
                if ($urandom % 3 != 0) d[3] = 1'b0;
            end
            ad = ($urandom % 5 == 0) ? (NS'(1) << ($urandom % NS)) : '0;
            rq = ($urandom % 4 == 0) ? (NS'(1) << ($urandom % NS)) : '0;
            cyc($urandom % 4 != 0, a, be, d, ad, rq);
            rd("R5 random status", 2'd1);
            rd("R12 random data", 2'd2);
            if (k % 50 == 0) rd("R4 random word0", 2'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule